// File: doc/BRIEF.md
# Coprocessor Select and Enable Controller

This block sits between a CPU and a set of up to seven attached coprocessors, numbered 1 to 7. It holds one shared control word, the coprocessor status register, which is reached as register number 0 of the coprocessor register space. The word carries one enable bit per unit, a 3-bit field that names the active unit, and a 4-bit operating mode that is handed to the active unit. From this word the block derives, for every unit, an enable line, a select line and a sleep line. A unit that is present and enabled but not the active one is told to sleep and keeps its register contents.

The CPU issues get (read) and set (write) requests that carry a 4-bit register number. Register number 0 is served locally from the status register. Any other number is forwarded, as a one-cycle strobe together with the register number, write flag and write data, to the active unit, and the read data of that unit is returned. If the active unit is absent (according to a presence vector input), disabled, or if no unit is active, the block raises a coprocessor trap instead and issues no strobe, so that software can emulate the missing unit.

The response (trap, read data and forwarded strobe) is combinational in the cycle of the request; a write to the status register takes effect at the next rising clock edge.

Top module: `cpx_select_ctrl`

## Requirements
- R1: After a synchronous active-high reset the status register is zero: a read of register 0 returns 0, and the enable, select, sleep and strobe outputs are all zero.
- R2: A set request to register 0 stores bits 7:1 of the write data as the enable bits of units 1 to 7 (bit k enables unit k, driven on cp_en[k-1]), bits 10:8 as the active unit number, and bits 15:12 as the mode; a later get of register 0 returns them in the same positions.
- R3: Bits 0, 11 and 31:16 of the status register always read as zero, whatever was written.
- R4: An enable bit can be set and read back for a unit whose presence bit is 0, and it is driven on cp_en.
- R5: cp_sel has exactly the bit of the active unit set (cp_sel[n-1] for active unit n) and is zero when the active unit number is 0; cp_mode always carries the stored mode.
- R6: cp_sleep[k-1] is 1 exactly when unit k is present, enabled and not the active unit; with active unit number 0 every present enabled unit sleeps.
- R7: A get or set request with a nonzero register number, whose active unit is present and enabled, drives cp_req only for that unit in the same cycle, passes the register number, write flag and write data on cp_reg, cp_write and cp_wdata, returns that unit's read data on rsp_rdata for a get, and does not raise rsp_trap.
- R8: A request with a nonzero register number raises rsp_trap when the active unit number is 0, or the active unit is absent or disabled; then no cp_req bit is set and rsp_rdata is 0.
- R9: A request to register 0 never raises rsp_trap and never sets any cp_req bit, whatever the status and presence.
- R10: A set of register 0 leaves the outputs unchanged during the request cycle and becomes visible after the next rising clock edge; set requests to other registers never change the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present this cycle |
| req_write | input | 1 | 1 for set (write), 0 for get (read) |
| req_reg | input | 4 | Coprocessor register number; 0 is the status register |
| req_wdata | input | 32 | Write data for a set |
| rsp_rdata | output | 32 | Read data for a get; 0 on trap |
| rsp_trap | output | 1 | Coprocessor trap for this request |
| cp_present | input | 7 | Bit k-1 is 1 when unit k exists |
| cp_en | output | 7 | Per-unit enable |
| cp_sel | output | 7 | Per-unit select (one-hot or zero) |
| cp_sleep | output | 7 | Per-unit sleep indication |
| cp_mode | output | 4 | Operating mode for the active unit |
| cp_req | output | 7 | Per-unit access strobe |
| cp_write | output | 1 | Forwarded write flag |
| cp_reg | output | 4 | Forwarded register number |
| cp_wdata | output | 32 | Forwarded write data |
| cp_rdata | input | 224 | Read data of all units, unit k in bits 32k-1 down to 32k-32 |

## Verification
The bench goes after the trap boundaries one at a time: active number 0, an active unit that is enabled but absent, and one that is present but disabled; a design that checked only presence or only enable would forward a strobe to a unit that cannot answer, and one that forgot the zero select would strobe nothing yet report no trap. It writes all ones to the status register to catch reserved bits that leak back, and an enable pattern for absent units to catch an enable that is masked by presence. Register 0 accesses are made while no unit is usable, so a design that trapped them would lock software out of its own control word. It also samples the outputs before and after the edge of a status write, so a design that let the write pass through combinationally, or that let a set to another register disturb the status word, shows a wrong value.

// File: rtl/cpsel_pkg.sv
package cpsel_pkg;

    localparam int NUM_UNITS = 7;
    localparam int DATA_W    = 32;
    localparam int REG_W     = 4;
    localparam int MODE_W    = 4;
    localparam int SEL_W     = $clog2(NUM_UNITS + 1);

    // Field positions inside the status word
    localparam int EN_LSB    = 1;
    localparam int SEL_LSB   = 8;
    localparam int MODE_LSB  = 12;

    localparam int RDATA_W   = NUM_UNITS * DATA_W;

    typedef struct packed {
        logic [MODE_W-1:0]    mode;
        logic [SEL_W-1:0]     sel;
        logic [NUM_UNITS-1:0] en;
    } cstat_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOCAL = 2'd1,
        ACC_FWD   = 2'd2,
        ACC_TRAP  = 2'd3
    } acc_kind_t;

    function automatic cstat_t word_to_status(input logic [DATA_W-1:0] w);
        cstat_t s;
        s.en   = w[EN_LSB   +: NUM_UNITS];
        s.sel  = w[SEL_LSB  +: SEL_W];
        s.mode = w[MODE_LSB +: MODE_W];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] status_to_word(input cstat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_LSB   +: NUM_UNITS] = s.en;
        w[SEL_LSB  +: SEL_W]     = s.sel;
        w[MODE_LSB +: MODE_W]    = s.mode;
        return w;
    endfunction

endpackage

// File: rtl/cpsel_status_reg.sv
module cpsel_status_reg
    import cpsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cstat_t            stat
);

    cstat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (wr_en) begin
            stat_q <= word_to_status(wr_data);
        end
    end

    assign stat = stat_q;

endmodule

// File: rtl/cpsel_classify.sv
module cpsel_classify
    import cpsel_pkg::*;
(
    input  logic                 req_valid,
    input  logic [REG_W-1:0]     req_reg,
    input  cstat_t               stat,
    input  logic [NUM_UNITS-1:0] present,
    output logic [NUM_UNITS-1:0] sel_oh,
    output acc_kind_t            kind
);

    logic unit_here;
    logic unit_on;

    generate
        for (genvar i = 0; i < NUM_UNITS; i++) begin : g_dec
            assign sel_oh[i] = (stat.sel == SEL_W'(i + 1));
        end
    endgenerate

    assign unit_here = |(sel_oh & present);
    assign unit_on   = |(sel_oh & stat.en);

    always_comb begin
        if (!req_valid) begin
            kind = ACC_NONE;
        end else if (req_reg == '0) begin
            kind = ACC_LOCAL;
        end else if (unit_here && unit_on) begin
            kind = ACC_FWD;
        end else begin
            kind = ACC_TRAP;
        end
    end

endmodule

// File: rtl/cpsel_fanout.sv
module cpsel_fanout
    import cpsel_pkg::*;
(
    input  acc_kind_t            kind,
    input  cstat_t               stat,
    input  logic [NUM_UNITS-1:0] sel_oh,
    input  logic [NUM_UNITS-1:0] present,
    input  logic [RDATA_W-1:0]   unit_rdata,
    output logic [NUM_UNITS-1:0] unit_req,
    output logic [NUM_UNITS-1:0] unit_sleep,
    output logic [DATA_W-1:0]    rdata
);

    logic [DATA_W-1:0] picked;
    logic              fwd;

    assign fwd = (kind == ACC_FWD);

    generate
        for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
            assign unit_req[i]   = fwd & sel_oh[i];
            assign unit_sleep[i] = present[i] & stat.en[i] & ~sel_oh[i];
        end
    endgenerate

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (sel_oh[i]) begin
                picked = picked | unit_rdata[i*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        case (kind)
            ACC_LOCAL: rdata = status_to_word(stat);
            ACC_FWD:   rdata = picked;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpx_select_ctrl.sv
module cpx_select_ctrl
    import cpsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [REG_W-1:0]     req_reg,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_trap,
    input  logic [NUM_UNITS-1:0] cp_present,
    output logic [NUM_UNITS-1:0] cp_en,
    output logic [NUM_UNITS-1:0] cp_sel,
    output logic [NUM_UNITS-1:0] cp_sleep,
    output logic [MODE_W-1:0]    cp_mode,
    output logic [NUM_UNITS-1:0] cp_req,
    output logic                 cp_write,
    output logic [REG_W-1:0]     cp_reg,
    output logic [DATA_W-1:0]    cp_wdata,
    input  logic [RDATA_W-1:0]   cp_rdata
);

    cstat_t               stat;
    acc_kind_t            kind;
    logic [NUM_UNITS-1:0] sel_oh;
    logic                 stat_wr;

    // Only a set aimed at register 0 updates the shared word
    assign stat_wr = (kind == ACC_LOCAL) && req_write;

    cpsel_status_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (stat_wr),
        .wr_data (req_wdata),
        .stat    (stat)
    );

    cpsel_classify u_cls (
        .req_valid (req_valid),
        .req_reg   (req_reg),
        .stat      (stat),
        .present   (cp_present),
        .sel_oh    (sel_oh),
        .kind      (kind)
    );

    cpsel_fanout u_fan (
        .kind       (kind),
        .stat       (stat),
        .sel_oh     (sel_oh),
        .present    (cp_present),
        .unit_rdata (cp_rdata),
        .unit_req   (cp_req),
        .unit_sleep (cp_sleep),
        .rdata      (rsp_rdata)
    );

    assign rsp_trap = (kind == ACC_TRAP);
    assign cp_en    = stat.en;
    assign cp_sel   = sel_oh;
    assign cp_mode  = stat.mode;
    assign cp_write = req_write;
    assign cp_reg   = req_reg;
    assign cp_wdata = req_wdata;

endmodule

// File: rtl/cpsel_checker.sv
module cpsel_checker
    import cpsel_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [REG_W-1:0]     req_reg,
    input logic [DATA_W-1:0]    req_wdata,
    input logic [DATA_W-1:0]    rsp_rdata,
    input logic                 rsp_trap,
    input logic [NUM_UNITS-1:0] cp_present,
    input logic [NUM_UNITS-1:0] cp_en,
    input logic [NUM_UNITS-1:0] cp_sel,
    input logic [NUM_UNITS-1:0] cp_sleep,
    input logic [MODE_W-1:0]    cp_mode,
    input logic [NUM_UNITS-1:0] cp_req
);

    // R7: at most one unit is strobed
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cp_req));

    // R8: a trap never comes with a strobe and returns zero data
    a_r8_trap_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (cp_req == '0) && (rsp_rdata == '0));

    // R9: register 0 is local and never traps
    a_r9_local_no_trap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_reg == '0) |-> !rsp_trap && (cp_req == '0));

    // R3: reserved status bits read as zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_reg == '0) |->
            (rsp_rdata[0] == 1'b0) && (rsp_rdata[11] == 1'b0) && (rsp_rdata[31:16] == '0));

    // R6: the active unit never sleeps, and absent units never sleep
    a_r6_sleep_excl: assert property (@(posedge clk) disable iff (rst)
        ((cp_sleep & cp_sel) == '0) && ((cp_sleep & ~cp_present) == '0));

    // R5: select is one-hot or zero
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cp_sel));

    // R2, R10: a status write shows its mode after the edge
    a_r2_mode_update: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_reg == '0) |=> (cp_mode == $past(req_wdata[15:12])));

    // R10: other set requests leave the status outputs alone
    a_r10_other_keeps: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_reg != '0) |=> $stable(cp_en) && $stable(cp_sel) && $stable(cp_mode));

endmodule

bind cpx_select_ctrl cpsel_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_reg    (req_reg),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .rsp_trap   (rsp_trap),
    .cp_present (cp_present),
    .cp_en      (cp_en),
    .cp_sel     (cp_sel),
    .cp_sleep   (cp_sleep),
    .cp_mode    (cp_mode),
    .cp_req     (cp_req)
);

// File: tb/cpx_select_ctrl_bench.sv
module cpx_select_ctrl_bench;
    import cpsel_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [REG_W-1:0]     req_reg = '0;
    logic [DATA_W-1:0]    req_wdata = '0;
    logic [DATA_W-1:0]    rsp_rdata;
    logic                 rsp_trap;
    logic [NUM_UNITS-1:0] cp_present = 7'b0010101;
    logic [NUM_UNITS-1:0] cp_en;
    logic [NUM_UNITS-1:0] cp_sel;
    logic [NUM_UNITS-1:0] cp_sleep;
    logic [MODE_W-1:0]    cp_mode;
    logic [NUM_UNITS-1:0] cp_req;
    logic                 cp_write;
    logic [REG_W-1:0]     cp_reg;
    logic [DATA_W-1:0]    cp_wdata;
    logic [RDATA_W-1:0]   cp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpx_select_ctrl u_cpx_select_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap),
        .cp_present(cp_present), .cp_en(cp_en), .cp_sel(cp_sel), .cp_sleep(cp_sleep),
        .cp_mode(cp_mode), .cp_req(cp_req), .cp_write(cp_write), .cp_reg(cp_reg),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata)
    );

    // Unit model: read data names the unit and the register asked for
    function automatic logic [DATA_W-1:0] unit_word(input int unit, input logic [REG_W-1:0] r);
        return {16'hC0DE, 8'(unit), 4'h0, r};
    endfunction

    always_comb begin
        for (int k = 0; k < NUM_UNITS; k++) begin
            cp_rdata[k*DATA_W +: DATA_W] = unit_word(k + 1, cp_reg);
        end
    end

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present a request after a falling edge; outputs settle before sampling
    task automatic put_req(input logic wr, input logic [REG_W-1:0] r, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_reg   = r;
        req_wdata = d;
        #1;
    endtask

    task automatic end_req();
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_reg   = '0;
        req_wdata = '0;
        #1;
    endtask

    task automatic set_status(input logic [DATA_W-1:0] d);
        put_req(1'b1, 4'd0, d);
        end_req();
    endtask

    task automatic read_status(input string tag, input logic [DATA_W-1:0] exp);
        put_req(1'b0, 4'd0, '0);
        chk(tag, rsp_rdata, exp);
        end_req();
    endtask

    task automatic t_reset();
        read_status("R1 status after reset", 32'h0);
        chk("R1 cp_en", 32'(cp_en), 32'h0);
        chk("R1 cp_sel", 32'(cp_sel), 32'h0);
        chk("R1 cp_sleep", 32'(cp_sleep), 32'h0);
        chk("R1 cp_req", 32'(cp_req), 32'h0);
    endtask

    task automatic t_fields();
        set_status(32'hFFFF_FFFF);
        read_status("R3 reserved bits zero", 32'h0000_F7FE);
        set_status(32'h0000_5312);
        read_status("R2 field readback", 32'h0000_5312);
        chk("R4 cp_en absent unit 4", 32'(cp_en), 32'h09);
        chk("R5 cp_sel unit 3", 32'(cp_sel), 32'h04);
        chk("R5 cp_mode", 32'(cp_mode), 32'h5);
        chk("R6 sleep unit 1 only", 32'(cp_sleep), 32'h01);
        // Unit 3 is selected but disabled
        put_req(1'b0, 4'd2, '0);
        chk("R8 disabled unit trap", 32'(rsp_trap), 32'h1);
        chk("R8 disabled unit no strobe", 32'(cp_req), 32'h0);
        end_req();
        set_status(32'h0000_00FE);
        chk("R6 select 0 all sleep", 32'(cp_sleep), 32'h15);
        chk("R5 select 0 no sel", 32'(cp_sel), 32'h0);
    endtask

    task automatic t_forward();
        set_status(32'h0000_232A);
        chk("R6 sleep units 1 and 5", 32'(cp_sleep), 32'h11);
        put_req(1'b0, 4'd7, '0);
        chk("R7 get strobe", 32'(cp_req), 32'h04);
        chk("R7 get no trap", 32'(rsp_trap), 32'h0);
        chk("R7 get data", rsp_rdata, unit_word(3, 4'd7));
        chk("R7 get reg", 32'(cp_reg), 32'h7);
        chk("R7 get flag", 32'(cp_write), 32'h0);
        end_req();
        put_req(1'b1, 4'd15, 32'hDEAD_BEEF);
        chk("R7 set strobe", 32'(cp_req), 32'h04);
        chk("R7 set data", cp_wdata, 32'hDEAD_BEEF);
        chk("R7 set flag", 32'(cp_write), 32'h1);
        chk("R7 set no trap", 32'(rsp_trap), 32'h0);
        end_req();
        read_status("R10 other set keeps status", 32'h0000_232A);
    endtask

    task automatic t_traps();
        set_status(32'h0000_002A);
        put_req(1'b0, 4'd1, '0);
        chk("R8 select 0 trap", 32'(rsp_trap), 32'h1);
        chk("R8 select 0 no strobe", 32'(cp_req), 32'h0);
        chk("R8 select 0 data zero", rsp_rdata, 32'h0);
        end_req();
        put_req(1'b0, 4'd0, '0);
        chk("R9 reg 0 no trap", 32'(rsp_trap), 32'h0);
        chk("R9 reg 0 no strobe", 32'(cp_req), 32'h0);
        end_req();
        set_status(32'h0000_043A);
        put_req(1'b0, 4'd3, '0);
        chk("R8 absent unit trap", 32'(rsp_trap), 32'h1);
        chk("R8 absent unit data zero", rsp_rdata, 32'h0);
        end_req();
        set_status(32'h0000_0506);
        put_req(1'b1, 4'd4, 32'h1234_5678);
        chk("R8 disabled set trap", 32'(rsp_trap), 32'h1);
        chk("R8 disabled set no strobe", 32'(cp_req), 32'h0);
        end_req();
    endtask

    task automatic t_timing();
        set_status(32'h0000_232A);
        put_req(1'b1, 4'd0, 32'h0000_7502);
        chk("R10 sel before edge", 32'(cp_sel), 32'h04);
        chk("R10 mode before edge", 32'(cp_mode), 32'h2);
        chk("R9 set reg 0 no trap", 32'(rsp_trap), 32'h0);
        end_req();
        chk("R10 sel after edge", 32'(cp_sel), 32'h10);
        chk("R10 mode after edge", 32'(cp_mode), 32'h7);
        chk("R10 en after edge", 32'(cp_en), 32'h01);
        chk("R6 sleep after edge", 32'(cp_sleep), 32'h01);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        chk("R1 en after second reset", 32'(cp_en), 32'h0);
        chk("R1 sleep after second reset", 32'(cp_sleep), 32'h0);
        read_status("R1 status after second reset", 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_fields();
        t_forward();
        t_traps();
        t_timing();
        t_reset_again();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule